// File: doc/BRIEF.md
# Device Address Translation Cache

This block is a small, fully associative cache that sits inside an I/O device. It keeps translations the host translation agent has already returned, so a DMA engine that reuses an address does not have to send a new translation request. The cache serves many I/O functions at once. Each entry is therefore tagged with the function that owns it, and it carries its own power-of-two page size. The smallest page size is 4 KiB.

The lookup port is combinational. A requester presents a function ID, an untranslated address and an access type, and gets back one of three results in the same cycle: hit (with the translated address), permission fault, or miss. The fill port installs a translation that the host returned. The invalidate port drops every entry of one function that overlaps an aligned range. Page and range sizes are coded as `code`, where the size in bytes is 2^(12+code).

Top module: `dev_xlate_cache`

## Requirements
- R1: After reset no entry is valid, and every lookup misses (`lkHit`=0, `lkFault`=0, `lkXlAddr`=0). The rotation pointer starts at entry 0.
- R2: A lookup hits when three things hold: the entry is valid, its function equals `lkFunc`, and the address bits at and above position 12+code equal the stored untranslated base. On a hit `lkHit`=1 and the upper bits of `lkXlAddr` come from the stored translated base.
- R3: On a hit, address bits below position 12+code of the entry's page pass from `lkAddr` into `lkXlAddr` unchanged. The 12 lowest bits always pass through.
- R4: An entry of another function, or an entry whose page does not cover the address, gives no hit and no fault.
- R5: Each entry holds a read bit and a write bit. `lkWrite`=1 needs the write bit and `lkWrite`=0 needs the read bit. If the matching entry lacks the needed bit, the result is `lkFault`=1, `lkHit`=0 and `lkXlAddr`=0.
- R6: A fill goes into the lowest-numbered invalid entry when one exists. Lookups see the new entry from the next cycle on.
- R7: When all entries are valid, a fill replaces the entry at the rotation pointer. The pointer then moves on by one, wrapping from 15 to 0. Fills into a free entry do not move the pointer.
- R8: An invalidate clears, in one cycle, every valid entry of `invFunc` whose page overlaps the aligned block of 2^(12+`invPsz`) bytes that contains `invAddr`. Entries of other functions are kept.
- R9: When a fill and an invalidate come in the same cycle, the victim is chosen from the state before that edge, and the invalidate acts only on entries that already existed. The newly filled entry is valid afterwards even if it lies inside the invalidated range.
- R10: A lookup in the same cycle as a fill or an invalidate sees the cache contents from before that clock edge.
- R11: When several entries match a lookup, the lowest-numbered one decides the result.
- R12: While `lkValid`=0, `lkHit`, `lkFault` and `lkXlAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request present |
| lkFunc | input | FUNC_W | Requesting function ID |
| lkAddr | input | ADDR_W | Untranslated address to look up |
| lkWrite | input | 1 | 1 = write access, 0 = read access |
| lkHit | output | 1 | Translation found and access permitted |
| lkFault | output | 1 | Translation found but access not permitted |
| lkXlAddr | output | ADDR_W | Translated address on a hit, 0 otherwise |
| fillValid | input | 1 | Install a translation |
| fillFunc | input | FUNC_W | Function that owns the new entry |
| fillUAddr | input | ADDR_W | Untranslated page address |
| fillTAddr | input | ADDR_W | Translated page address |
| fillPsz | input | PSZ_W | Page size code, size = 2^(12+code) bytes |
| fillRead | input | 1 | Read permitted |
| fillWrite | input | 1 | Write permitted |
| invValid | input | 1 | Invalidate request |
| invFunc | input | FUNC_W | Function whose entries are invalidated |
| invAddr | input | ADDR_W | Any address inside the invalidated block |
| invPsz | input | PSZ_W | Invalidated block size code |

## Verification
Two pairs of functions can land in the same cycle: a fill with an invalidate, and a lookup with either of them. Directed cycles provoke both pairs. In one, a fill is issued whose page lies inside the range being invalidated. In another, an address is looked up in the very cycle its translation is installed. A long random phase then mixes all three ports with a few functions and overlapping pages. In every cycle, a behavioural reference model in the bench predicts the hit, fault and translated address. It applies the invalidate before the fill and picks the victim from the state before the edge, then compares its prediction with the outputs.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int ENTRIES   = 16;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int MIN_SHIFT = 12;

  typedef struct packed {
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
    logic             invEn;
  } xc_strobe_t;
endpackage

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               invValid,
  input  logic [ENTRIES-1:0] validVec,
  output xc_strobe_t         strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             freeFound;

  // lowest-numbered free entry
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe.fillEn  = fillValid;
    strobe.fillIdx = freeFound ? freeIdx : rrPtr;
    strobe.invEn   = invValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (fillValid && !freeFound) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
  end

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && (&validVec)) |=> (rrPtr == (($past(rrPtr) == LAST_IDX) ? '0 : $past(rrPtr) + 1'b1))); // R7
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!fillValid || !(&validVec)) |=> $stable(rrPtr)); // R7
  AST_FREE_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillEn && !(&validVec)) |-> !validVec[strobe.fillIdx]); // R6
endmodule

// File: rtl/xc_dpath.sv
module xc_dpath
  import xc_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int FUNC_W = 8,
  parameter int PSZ_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  xc_strobe_t         strobe,
  input  logic               lkValid,
  input  logic [FUNC_W-1:0]  lkFunc,
  input  logic [ADDR_W-1:0]  lkAddr,
  input  logic               lkWrite,
  output logic               lkHit,
  output logic               lkFault,
  output logic [ADDR_W-1:0]  lkXlAddr,
  input  logic [FUNC_W-1:0]  fillFunc,
  input  logic [ADDR_W-1:0]  fillUAddr,
  input  logic [ADDR_W-1:0]  fillTAddr,
  input  logic [PSZ_W-1:0]   fillPsz,
  input  logic               fillRead,
  input  logic               fillWrite,
  input  logic [FUNC_W-1:0]  invFunc,
  input  logic [ADDR_W-1:0]  invAddr,
  input  logic [PSZ_W-1:0]   invPsz,
  output logic [ENTRIES-1:0] validVec
);
  function automatic logic [ADDR_W-1:0] pageMask(input logic [PSZ_W-1:0] code);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) m[b] = (b >= MIN_SHIFT + int'(code));
    return m;
  endfunction

  logic [FUNC_W-1:0] eFunc  [ENTRIES];
  logic [ADDR_W-1:0] eUBase [ENTRIES];
  logic [ADDR_W-1:0] eTBase [ENTRIES];
  logic [PSZ_W-1:0]  ePsz   [ENTRIES];
  logic              eRd    [ENTRIES];
  logic              eWr    [ENTRIES];
  logic [ADDR_W-1:0] eMask  [ENTRIES];
  logic [ENTRIES-1:0] lkMatch, invHit;
  logic [ADDR_W-1:0] invMask, fillMask;

  assign invMask  = pageMask(invPsz);
  assign fillMask = pageMask(fillPsz);

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign eMask[g]   = pageMask(ePsz[g]);
    assign lkMatch[g] = validVec[g] && (eFunc[g] == lkFunc) &&
                        (((lkAddr ^ eUBase[g]) & eMask[g]) == '0);
    // aligned power-of-two blocks overlap iff they agree above the larger size
    assign invHit[g]  = validVec[g] && (eFunc[g] == invFunc) &&
                        (((invAddr ^ eUBase[g]) & eMask[g] & invMask) == '0);

    always_ff @(posedge clk) begin
      if (!rstN) validVec[g] <= 1'b0;
      else begin
        if (strobe.invEn && invHit[g]) validVec[g] <= 1'b0;
        if (strobe.fillEn && strobe.fillIdx == IDX_W'(g)) validVec[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.fillEn && strobe.fillIdx == IDX_W'(g)) begin
        eFunc[g]  <= fillFunc;
        eUBase[g] <= fillUAddr & fillMask;
        eTBase[g] <= fillTAddr & fillMask;
        ePsz[g]   <= fillPsz;
        eRd[g]    <= fillRead;
        eWr[g]    <= fillWrite;
      end
    end
  end

  logic             anyMatch;
  logic [IDX_W-1:0] sel;
  logic             permOk;

  always_comb begin
    anyMatch = 1'b0;
    sel      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        anyMatch = 1'b1;
        sel      = IDX_W'(i);
      end
    end
    permOk   = lkWrite ? eWr[sel] : eRd[sel];
    lkHit    = lkValid && anyMatch && permOk;
    lkFault  = lkValid && anyMatch && !permOk;
    lkXlAddr = lkHit ? ((eTBase[sel] & eMask[sel]) | (lkAddr & ~eMask[sel])) : '0;
  end

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> validVec[$past(strobe.fillIdx)]); // R6
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.invEn && !strobe.fillEn) |=> ((validVec & $past(invHit)) == '0)); // R8
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkXlAddr[MIN_SHIFT-1:0] == lkAddr[MIN_SHIFT-1:0])); // R3
endmodule

// File: rtl/dev_xlate_cache.sv
module dev_xlate_cache
  import xc_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int FUNC_W = 8,
  parameter int PSZ_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [FUNC_W-1:0] lkFunc,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  output logic              lkHit,
  output logic              lkFault,
  output logic [ADDR_W-1:0] lkXlAddr,
  input  logic              fillValid,
  input  logic [FUNC_W-1:0] fillFunc,
  input  logic [ADDR_W-1:0] fillUAddr,
  input  logic [ADDR_W-1:0] fillTAddr,
  input  logic [PSZ_W-1:0]  fillPsz,
  input  logic              fillRead,
  input  logic              fillWrite,
  input  logic              invValid,
  input  logic [FUNC_W-1:0] invFunc,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic [PSZ_W-1:0]  invPsz
);
  xc_strobe_t         strobe;
  logic [ENTRIES-1:0] validVec;

  xc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .invValid(invValid),
    .validVec(validVec), .strobe(strobe)
  );

  xc_dpath #(.ADDR_W(ADDR_W), .FUNC_W(FUNC_W), .PSZ_W(PSZ_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lkValid(lkValid), .lkFunc(lkFunc), .lkAddr(lkAddr), .lkWrite(lkWrite),
    .lkHit(lkHit), .lkFault(lkFault), .lkXlAddr(lkXlAddr),
    .fillFunc(fillFunc), .fillUAddr(fillUAddr), .fillTAddr(fillTAddr),
    .fillPsz(fillPsz), .fillRead(fillRead), .fillWrite(fillWrite),
    .invFunc(invFunc), .invAddr(invAddr), .invPsz(invPsz),
    .validVec(validVec)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !lkFault && lkXlAddr == '0)); // R12
endmodule

// File: tb/sim_dev_xlate_cache.sv
module sim_dev_xlate_cache;
  localparam int AW = 40;
  localparam int FW = 8;
  localparam int PW = 5;
  localparam int N  = 16;

  logic clk = 0;
  logic rstN = 0;
  logic lkValid = 0, lkWrite = 0, fillValid = 0, fillRead = 0, fillWrite = 0, invValid = 0;
  logic [FW-1:0] lkFunc = 0, fillFunc = 0, invFunc = 0;
  logic [AW-1:0] lkAddr = 0, fillUAddr = 0, fillTAddr = 0, invAddr = 0;
  logic [PW-1:0] fillPsz = 0, invPsz = 0;
  logic lkHit, lkFault;
  logic [AW-1:0] lkXlAddr;

  always #5 clk = ~clk;

  dev_xlate_cache u0 (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkFunc(lkFunc), .lkAddr(lkAddr),
    .lkWrite(lkWrite), .lkHit(lkHit), .lkFault(lkFault), .lkXlAddr(lkXlAddr),
    .fillValid(fillValid), .fillFunc(fillFunc), .fillUAddr(fillUAddr),
    .fillTAddr(fillTAddr), .fillPsz(fillPsz), .fillRead(fillRead),
    .fillWrite(fillWrite), .invValid(invValid), .invFunc(invFunc),
    .invAddr(invAddr), .invPsz(invPsz)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R1 reset";

  // reference model
  bit          mV [N];
  logic [FW-1:0] mF [N];
  logic [AW-1:0] mU [N];
  logic [AW-1:0] mT [N];
  int          mP [N];
  bit          mR [N];
  bit          mW [N];
  int          mPtr = 0;

  function automatic logic [AW-1:0] msk(input int code);
    return {AW{1'b1}} << (12 + code);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, phase, act, exp);
    end
  endtask

  task automatic compare();
    int idx = -1;
    bit eHit = 0, eFault = 0;
    logic [AW-1:0] eX = 0;
    string tag;
    for (int i = 0; i < N; i++)
      if (idx < 0 && mV[i] && mF[i] == lkFunc && ((lkAddr ^ mU[i]) & msk(mP[i])) == 0) idx = i;
    if (lkValid && idx >= 0) begin
      if (lkWrite ? mW[idx] : mR[idx]) begin
        eHit = 1;
        eX = (mT[idx] & msk(mP[idx])) | (lkAddr & ~msk(mP[idx]));
      end else eFault = 1;
    end
    tag = !rstN ? "R1" : !lkValid ? "R12" : eHit ? "R2" : eFault ? "R5" : "R4";
    chk(lkHit == eHit, {tag, " hit"}, AW'(lkHit), AW'(eHit));
    chk(lkFault == eFault, {tag, " fault"}, AW'(lkFault), AW'(eFault));
    chk(lkXlAddr == eX, eHit ? "R3 xlate" : {tag, " xlate"}, lkXlAddr, eX);
  endtask

  task automatic update();
    int victim = -1;
    bit evict = 0;
    if (!rstN) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
      mPtr = 0;
      return;
    end
    for (int i = 0; i < N; i++) if (victim < 0 && !mV[i]) victim = i;
    if (victim < 0) begin victim = mPtr; evict = 1; end
    if (invValid)
      for (int i = 0; i < N; i++) begin
        int big = (mP[i] > int'(invPsz)) ? mP[i] : int'(invPsz);
        if (mV[i] && mF[i] == invFunc && ((mU[i] ^ invAddr) & msk(big)) == 0) mV[i] = 0;
      end
    if (fillValid) begin
      mV[victim] = 1; mF[victim] = fillFunc; mP[victim] = int'(fillPsz);
      mU[victim] = fillUAddr & msk(int'(fillPsz));
      mT[victim] = fillTAddr & msk(int'(fillPsz));
      mR[victim] = fillRead; mW[victim] = fillWrite;
      if (evict) mPtr = (mPtr + 1) % N;
    end
  endtask

  // inputs are set at negedge; compare, then let the edge pass and update model
  task automatic tick();
    #1 compare();
    @(posedge clk);
    #1 update();
    @(negedge clk);
  endtask

  task automatic idle();
    lkValid = 0; fillValid = 0; invValid = 0;
  endtask

  task automatic setLook(input int f, input logic [AW-1:0] a, input bit w);
    lkValid = 1; lkFunc = FW'(f); lkAddr = a; lkWrite = w;
  endtask

  task automatic setFill(input int f, input logic [AW-1:0] ua, input logic [AW-1:0] ta,
                         input int psz, input bit rd, input bit wr);
    fillValid = 1; fillFunc = FW'(f); fillUAddr = ua; fillTAddr = ta;
    fillPsz = PW'(psz); fillRead = rd; fillWrite = wr;
  endtask

  task automatic setInv(input int f, input logic [AW-1:0] a, input int psz);
    invValid = 1; invFunc = FW'(f); invAddr = a; invPsz = PW'(psz);
  endtask

  function automatic logic [AW-1:0] rndAddr();
    return (AW'($urandom_range(0, 15)) << 22) | AW'($urandom_range(0, (1 << 22) - 1));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog [%s] act=hung exp=done", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: outputs idle during and after reset
    setLook(1, 40'h12345678, 0);
    tick(); tick();
    rstN = 1;
    tick();

    phase = "R2 R3 R4 basic";
    idle(); setFill(1, 40'h12345ABC, 40'hABCDE123, 0, 1, 1); tick();
    idle(); setLook(1, 40'h123457FF, 0); tick();     // R2 R3 hit, low bits pass
    setLook(1, 40'h123457FF, 1); tick();
    setLook(2, 40'h123457FF, 0); tick();             // R4 other function misses
    setLook(1, 40'h12346000, 0); tick();             // R4 next page misses

    phase = "R5 permission";
    idle(); setFill(1, 40'h40000000, 40'h9A00000, 9, 1, 0); tick();
    idle(); setLook(1, 40'h401FFFF8, 1); tick();     // write to read-only: fault
    setLook(1, 40'h401FFFF8, 0); tick();             // R3 big page pass-through
    idle(); setFill(2, 40'h50000000, 40'h70000000, 0, 0, 1); tick();
    idle(); setLook(2, 40'h50000010, 0); tick();     // read to write-only: fault

    phase = "R12 idle lookup";
    idle(); lkFunc = 1; lkAddr = 40'h123457FF; tick();

    phase = "R10 lookup during fill";
    idle(); setFill(3, 40'h60000000, 40'h11000000, 0, 1, 1);
    setLook(3, 40'h60000004, 0); tick();             // sees old state: miss
    idle(); setLook(3, 40'h60000004, 0); tick();

    phase = "R11 multiple matches";
    idle(); setFill(3, 40'h80000000, 40'h2000000, 8, 1, 1); tick();
    idle(); setFill(3, 40'h80001000, 40'h3000000, 0, 1, 0); tick();
    idle(); setLook(3, 40'h80001234, 0); tick();
    setLook(3, 40'h80001234, 1); tick();

    phase = "R6 R7 rotation";
    for (int k = 0; k < 24; k++) begin
      idle(); setFill(4, 40'h100000000 + AW'(k) * 40'h1000, 40'h200000000 + AW'(k) * 40'h1000, 0, 1, 1);
      setLook(4, 40'h100000000 + AW'((k + 3) % 24) * 40'h1000, 0); tick();
    end
    for (int k = 0; k < 24; k++) begin
      idle(); setLook(4, 40'h100000000 + AW'(k) * 40'h1000 + 40'h88, 0); tick();
    end

    phase = "R8 invalidate";
    idle(); setFill(5, 40'hA0000000, 40'hB0000000, 0, 1, 1); tick();
    idle(); setFill(6, 40'hA0000000, 40'hC0000000, 0, 1, 1); tick();
    idle(); setInv(5, 40'hA0000800, 4); tick();      // 64 KiB block covers page
    idle(); setLook(5, 40'hA0000010, 0); tick();
    setLook(6, 40'hA0000010, 0); tick();             // other function kept
    idle(); setInv(4, 40'h100000000, 5); tick();
    for (int k = 0; k < 24; k += 5) begin
      idle(); setLook(4, 40'h100000000 + AW'(k) * 40'h1000, 0); tick();
    end

    phase = "R9 fill with invalidate";
    idle(); setFill(7, 40'hD0002000, 40'hE0002000, 0, 1, 1);
    setInv(7, 40'hD0000000, 3); tick();
    idle(); setLook(7, 40'hD0002040, 0); tick();
    idle(); setFill(7, 40'hD0003000, 40'hE0003000, 0, 1, 1);
    setInv(7, 40'hD0002000, 0); tick();
    idle(); setLook(7, 40'hD0002040, 0); tick();
    setLook(7, 40'hD0003040, 0); tick();

    phase = "random mix";
    for (int k = 0; k < 4000; k++) begin
      idle();
      if ($urandom_range(0, 3) == 0)
        setFill($urandom_range(0, 3), rndAddr(), rndAddr(), $urandom_range(0, 10),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 9) == 0)
        setInv($urandom_range(0, 3), rndAddr(), $urandom_range(0, 12));
      if ($urandom_range(0, 4) != 0)
        setLook($urandom_range(0, 3), rndAddr(), 1'($urandom_range(0, 1)));
      tick();
    end

    phase = "R1 reset again";
    idle(); rstN = 0; tick();
    rstN = 1; setLook(4, 40'h100000000, 0); tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule